// File: doc/BRIEF.md
# Effective Address and Cycle Unit

This unit sits beside the decoder of a small 8-bit accumulator processor. For each instruction the decoder hands it an addressing-mode code, the 16-bit operand field, the two index registers, the accumulator and a 2-bit instruction class. The unit works out the effective address and fetches the operand byte, walking a pointer in page 0 first when the mode is indirect. It also reports the instruction length in bytes and the number of machine cycles the instruction costs.

All memory traffic goes through one synchronous byte-wide read port. Read data appears one clock after the request. A one-clock `start` pulse begins an operation. A one-clock `done` pulse ends it, and the results stay on the outputs until the next accepted `start`. The cycle figure is drawn from a separate table for each of three classes: load/compare style reads, read-modify-write and stores. Reads whose indexing carries into a new page cost one cycle more. Every instruction of the remaining class is given a single fixed cost.

Top module: `ea_cycle_unit`

## Requirements
- R1: Mode codes are 0 immediate, 1 accumulator, 2 zero-page, 3 zero-page+X, 4 zero-page+Y, 5 absolute, 6 absolute+X, 7 absolute+Y, 8 pre-indexed indirect, 9 post-indexed indirect, 10 implied, 11 indirect jump, 12 relative, and 13-15 reserved. The zero-page modes give {8'h00, (operand[7:0] + index) mod 256}. Absolute gives the operand as it is. The absolute indexed modes give (operand + index) mod 65536.
- R2: Mode 8 reads a pointer low byte at page-0 address (operand[7:0]+X) mod 256 and the high byte at that address + 1, also mod 256. The effective address is {high, low}.
- R3: Mode 9 reads the pointer low byte at page-0 address operand[7:0] and the high byte at (operand[7:0]+1) mod 256. The effective address is ({high, low} + Y) mod 65536.
- R4: Immediate returns operand[7:0] as the value, and accumulator mode returns the accumulator. Both report address 0. Modes 10-15 report address 0 and value 0. None of these modes issues a memory read. Every other mode reads exactly one data byte at the effective address and returns it.
- R5: Length is 3 for modes 5-7, 1 for modes 1 and 10, and 2 for every other code.
- R6: Class codes are 0 read, 1 read-modify-write, 2 store, 3 other. The read-class base cost is: immediate 2, zero-page 3, zero-page+X, absolute and absolute+X/+Y 4, post-indexed indirect 5, pre-indexed indirect 6. Any mode not listed for the class reports 0.
- R7: The read-modify-write base cost is: accumulator 2, zero-page 5, zero-page+X and absolute 6, absolute+X 7. Any other mode reports 0.
- R8: The store cost is: zero-page 3, zero-page+X and absolute 4, absolute+X/+Y 5, both indirect modes 6. Any other mode reports 0. A page crossing never changes the store cost.
- R9: Class 3 reports OTHER_CYCLES (default 2) for every mode.
- R10: In the read class only, modes 6, 7 and 9 add one cycle when the high byte of the indexed address differs from the high byte of the unindexed base (the operand, or the pointer for mode 9).
- R11: Read data is valid on `mem_rdata` one clock after `mem_rd`. `done` is high for exactly one clock after the last needed byte has been captured. `busy` is high from the accepted `start` through the `done` clock. A `start` while busy is ignored. The results hold until the next accepted `start`.
- R12: After reset, `done`, `busy` and `mem_rd` are low and all result outputs are 0. Reset is asserted asynchronously and released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 4 | Addressing-mode code |
| iclass | input | 2 | Instruction class code |
| operand | input | 16 | Operand field of the instruction |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| acc | input | 8 | Accumulator |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, one clock after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| eff_addr | output | 16 | Effective address |
| value | output | 8 | Operand value |
| length | output | 2 | Instruction length in bytes |
| cycles | output | 4 | Machine cycle count |

## Verification
The bench aims at carries that should be dropped. These are the zero-page+X sum past 0xFF, a pointer at 0xFF whose high byte must come from 0x00, and an absolute+Y sum that wraps past 0xFFFF. A design that let any of these carry would leave page 0 or return a 17-bit-style address. Page-crossing cases are run in all three classes: a design that charged the penalty outside the read class, or missed it on the post-indexed pointer, would be one cycle off. Unlisted mode/class pairs must report 0, and reserved codes must issue no read. A `start` pulsed mid-operation must change nothing: a design that restarted would return the wrong address and emit two `done` pulses.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_IMM  = 4'd0,
    AM_ACC  = 4'd1,
    AM_ZP   = 4'd2,
    AM_ZPX  = 4'd3,
    AM_ZPY  = 4'd4,
    AM_ABS  = 4'd5,
    AM_ABSX = 4'd6,
    AM_ABSY = 4'd7,
    AM_INDX = 4'd8,
    AM_INDY = 4'd9,
    AM_IMP  = 4'd10,
    AM_IND  = 4'd11,
    AM_REL  = 4'd12
  } amode_e;

  typedef enum logic [1:0] {
    IC_READ  = 2'd0,
    IC_RMW   = 2'd1,
    IC_STORE = 2'd2,
    IC_OTHER = 2'd3
  } iclass_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PLO  = 3'd1,
    ST_PHI  = 3'd2,
    ST_PCAP = 3'd3,
    ST_DRD  = 3'd4,
    ST_DCAP = 3'd5,
    ST_DONE = 3'd6
  } ea_state_e;

endpackage

// File: rtl/ea_cost.sv
module ea_cost
  import ea_pkg::*;
#(
  parameter int CW           = 4,
  parameter int OTHER_CYCLES = 2
) (
  input  logic [3:0]    mode,
  input  logic [1:0]    iclass,
  output logic [1:0]    len,
  output logic [CW-1:0] base,
  output logic          pen_ok
);

  always_comb begin
    case (mode)
      AM_ABS, AM_ABSX, AM_ABSY: len = 2'd3;
      AM_ACC, AM_IMP:           len = 2'd1;
      default:                  len = 2'd2;
    endcase
  end

  always_comb begin
    base = '0;
    case (iclass)
      IC_READ: begin
        case (mode)
          AM_IMM:                            base = CW'(2);
          AM_ZP:                             base = CW'(3);
          AM_ZPX, AM_ABS, AM_ABSX, AM_ABSY:  base = CW'(4);
          AM_INDY:                           base = CW'(5);
          AM_INDX:                           base = CW'(6);
          default:                           base = '0;
        endcase
      end
      IC_RMW: begin
        case (mode)
          AM_ACC:         base = CW'(2);
          AM_ZP:          base = CW'(5);
          AM_ZPX, AM_ABS: base = CW'(6);
          AM_ABSX:        base = CW'(7);
          default:        base = '0;
        endcase
      end
      IC_STORE: begin
        case (mode)
          AM_ZP:            base = CW'(3);
          AM_ZPX, AM_ABS:   base = CW'(4);
          AM_ABSX, AM_ABSY: base = CW'(5);
          AM_INDX, AM_INDY: base = CW'(6);
          default:          base = '0;
        endcase
      end
      default: base = CW'(OTHER_CYCLES);
    endcase
  end

  assign pen_ok = (iclass == IC_READ) &&
                  ((mode == AM_ABSX) || (mode == AM_ABSY) || (mode == AM_INDY));

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] operand,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [AW-1:0] ptr_word,
  output logic [AW-1:0] direct_ea,
  output logic          direct_cross,
  output logic [DW-1:0] ptr_base,
  output logic          need_ptr,
  output logic          need_data,
  output logic [AW-1:0] ind_ea,
  output logic          ind_cross
);

  logic [AW-1:0] sum_x, sum_y;
  logic [DW-1:0] zp_x, zp_y;

  assign sum_x = operand + AW'(idx_x);
  assign sum_y = operand + AW'(idx_y);
  assign zp_x  = operand[DW-1:0] + idx_x;
  assign zp_y  = operand[DW-1:0] + idx_y;

  always_comb begin
    direct_ea    = '0;
    direct_cross = 1'b0;
    case (mode)
      AM_ZP:   direct_ea = {{DW{1'b0}}, operand[DW-1:0]};
      AM_ZPX:  direct_ea = {{DW{1'b0}}, zp_x};
      AM_ZPY:  direct_ea = {{DW{1'b0}}, zp_y};
      AM_ABS:  direct_ea = operand;
      AM_ABSX: begin
        direct_ea    = sum_x;
        direct_cross = (sum_x[AW-1:DW] != operand[AW-1:DW]);
      end
      AM_ABSY: begin
        direct_ea    = sum_y;
        direct_cross = (sum_y[AW-1:DW] != operand[AW-1:DW]);
      end
      default: ;
    endcase
  end

  assign need_ptr  = (mode == AM_INDX) || (mode == AM_INDY);
  assign need_data = need_ptr || (mode >= AM_ZP && mode <= AM_ABSY);
  assign ptr_base  = (mode == AM_INDX) ? zp_x : operand[DW-1:0];

  always_comb begin
    if (mode == AM_INDY) begin
      ind_ea    = ptr_word + AW'(idx_y);
      ind_cross = (ind_ea[AW-1:DW] != ptr_word[AW-1:DW]);
    end else begin
      ind_ea    = ptr_word;
      ind_cross = 1'b0;
    end
  end

endmodule

// File: rtl/ea_cycle_unit.sv
module ea_cycle_unit
  import ea_pkg::*;
#(
  parameter int DW           = 8,
  parameter int CW           = 4,
  parameter int OTHER_CYCLES = 2,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [1:0]    iclass,
  input  logic [AW-1:0] operand,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] acc,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] eff_addr,
  output logic [DW-1:0] value,
  output logic [1:0]    length,
  output logic [CW-1:0] cycles
);

  // reset: asynchronous assert, clock-aligned release
  logic rs_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_s   <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_s   <= rs_meta;
    end
  end

  ea_state_e     st_q, st_d;
  logic [3:0]    mode_q, mode_d;
  logic [1:0]    cls_q, cls_d;
  logic [AW-1:0] op_q, op_d;
  logic [DW-1:0] x_q, x_d, y_q, y_d, plo_q, plo_d, val_q, val_d;
  logic [AW-1:0] ea_q, ea_d;
  logic [1:0]    len_q, len_d;
  logic [CW-1:0] base_q, base_d;
  logic          penok_q, penok_d, pen_q, pen_d;

  logic          idle, accept;
  logic [3:0]    sel_mode;
  logic [1:0]    sel_cls;
  logic [AW-1:0] sel_op;
  logic [DW-1:0] sel_x, sel_y;

  assign idle     = (st_q == ST_IDLE);
  assign accept   = idle && start;
  assign sel_mode = idle ? mode    : mode_q;
  assign sel_cls  = idle ? iclass  : cls_q;
  assign sel_op   = idle ? operand : op_q;
  assign sel_x    = idle ? idx_x   : x_q;
  assign sel_y    = idle ? idx_y   : y_q;

  logic [1:0]    c_len;
  logic [CW-1:0] c_base;
  logic          c_penok;

  ea_cost #(.CW(CW), .OTHER_CYCLES(OTHER_CYCLES)) u_cost (
    .mode   (sel_mode),
    .iclass (sel_cls),
    .len    (c_len),
    .base   (c_base),
    .pen_ok (c_penok)
  );

  logic [AW-1:0] g_direct_ea, g_ind_ea;
  logic          g_direct_cross, g_ind_cross, g_need_ptr, g_need_data;
  logic [DW-1:0] g_ptr_base;

  ea_addr_gen #(.DW(DW)) u_addr (
    .mode         (sel_mode),
    .operand      (sel_op),
    .idx_x        (sel_x),
    .idx_y        (sel_y),
    .ptr_word     ({mem_rdata, plo_q}),
    .direct_ea    (g_direct_ea),
    .direct_cross (g_direct_cross),
    .ptr_base     (g_ptr_base),
    .need_ptr     (g_need_ptr),
    .need_data    (g_need_data),
    .ind_ea       (g_ind_ea),
    .ind_cross    (g_ind_cross)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    cls_d   = cls_q;
    op_d    = op_q;
    x_d     = x_q;
    y_d     = y_q;
    plo_d   = plo_q;
    val_d   = val_q;
    ea_d    = ea_q;
    len_d   = len_q;
    base_d  = base_q;
    penok_d = penok_q;
    pen_d   = pen_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          mode_d  = mode;
          cls_d   = iclass;
          op_d    = operand;
          x_d     = idx_x;
          y_d     = idx_y;
          len_d   = c_len;
          base_d  = c_base;
          penok_d = c_penok;
          pen_d   = c_penok && g_direct_cross;
          ea_d    = g_direct_ea;
          if (mode == AM_IMM)      val_d = operand[DW-1:0];
          else if (mode == AM_ACC) val_d = acc;
          else                     val_d = '0;
          if (g_need_ptr)       st_d = ST_PLO;
          else if (g_need_data) st_d = ST_DRD;
          else                  st_d = ST_DONE;
        end
      end
      ST_PLO:  st_d = ST_PHI;
      ST_PHI: begin
        plo_d = mem_rdata;
        st_d  = ST_PCAP;
      end
      ST_PCAP: begin
        ea_d  = g_ind_ea;
        pen_d = penok_q && g_ind_cross;
        st_d  = ST_DRD;
      end
      ST_DRD:  st_d = ST_DCAP;
      ST_DCAP: begin
        val_d = mem_rdata;
        st_d  = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      mode_q  <= '0;
      cls_q   <= '0;
      op_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      plo_q   <= '0;
      val_q   <= '0;
      ea_q    <= '0;
      len_q   <= '0;
      base_q  <= '0;
      penok_q <= 1'b0;
      pen_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      cls_q   <= cls_d;
      op_q    <= op_d;
      x_q     <= x_d;
      y_q     <= y_d;
      plo_q   <= plo_d;
      val_q   <= val_d;
      ea_q    <= ea_d;
      len_q   <= len_d;
      base_q  <= base_d;
      penok_q <= penok_d;
      pen_q   <= pen_d;
    end
  end

  // memory port
  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = '0;
    case (st_q)
      ST_PLO: begin
        mem_rd   = 1'b1;
        mem_addr = {{DW{1'b0}}, g_ptr_base};
      end
      ST_PHI: begin
        mem_rd   = 1'b1;
        mem_addr = {{DW{1'b0}}, g_ptr_base + DW'(1)};
      end
      ST_DRD: begin
        mem_rd   = 1'b1;
        mem_addr = ea_q;
      end
      default: ;
    endcase
  end

  assign busy     = !idle;
  assign done     = (st_q == ST_DONE);
  assign eff_addr = ea_q;
  assign value    = val_q;
  assign length   = len_q;
  assign cycles   = base_q + CW'(pen_q);

  // checks
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && start) |=> $stable(mode_q) && $stable(op_q));

  assert_read_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_s)
    mem_rd |-> busy);

  // pointer fetches for R2 and R3 stay inside page 0
  assert_ptr_page0_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_PLO || st_q == ST_PHI) |-> (mem_addr[AW-1:DW] == '0));

  assert_zp_page0_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (done && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
      |-> (eff_addr[AW-1:DW] == '0));

  assert_store_max_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (done && cls_q == IC_STORE) |-> (cycles <= CW'(6)));

  assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (length != 2'd0));

endmodule

// File: tb/ea_cycle_unit_test.sv
module ea_cycle_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  iclass = '0;
  logic [15:0] operand = '0;
  logic [7:0]  idx_x = '0, idx_y = '0, acc = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done;
  logic [15:0] eff_addr;
  logic [7:0]  value;
  logic [1:0]  length;
  logic [3:0]  cycles;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int cyc_cnt = 0;

  always #10 clk = ~clk;

  ea_cycle_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .iclass(iclass),
    .operand(operand), .idx_x(idx_x), .idx_y(idx_y), .acc(acc),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .eff_addr(eff_addr), .value(value),
    .length(length), .cycles(cycles)
  );

  // computed memory contents: page 0 holds addr+0x40, elsewhere lo^hi
  function automatic logic [7:0] memf(input logic [15:0] a);
    if (a[15:8] == 8'h00) return a[7:0] + 8'h40;
    return a[7:0] ^ a[15:8];
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= memf(mem_addr);
      rd_cnt = rd_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc_cnt = cyc_cnt + 1;
    if (cyc_cnt > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_ea(input logic [3:0] m, input logic [15:0] op,
                                         input logic [7:0] x, input logic [7:0] y);
    logic [7:0] p;
    case (m)
      4'd2: return {8'h00, op[7:0]};
      4'd3: return {8'h00, op[7:0] + x};
      4'd4: return {8'h00, op[7:0] + y};
      4'd5: return op;
      4'd6: return op + {8'h00, x};
      4'd7: return op + {8'h00, y};
      4'd8: begin
        p = op[7:0] + x;
        return {memf({8'h00, p + 8'd1}), memf({8'h00, p})};
      end
      4'd9: begin
        p = op[7:0];
        return {memf({8'h00, p + 8'd1}), memf({8'h00, p})} + {8'h00, y};
      end
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int ref_reads(input logic [3:0] m);
    if (m == 4'd8 || m == 4'd9) return 3;
    if (m >= 4'd2 && m <= 4'd7) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] ref_val(input logic [3:0] m, input logic [15:0] op,
                                         input logic [7:0] x, input logic [7:0] y,
                                         input logic [7:0] a);
    if (m == 4'd0) return op[7:0];
    if (m == 4'd1) return a;
    if (ref_reads(m) > 0) return memf(ref_ea(m, op, x, y));
    return 8'h00;
  endfunction

  typedef struct packed {
    logic [3:0]  m;
    logic [1:0]  c;
    logic [15:0] op;
    logic [7:0]  x;
    logic [7:0]  y;
    logic [7:0]  a;
    logic [1:0]  len;
    logic [3:0]  cyc;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VT [NV] = '{
    '{4'd0,  2'd0, 16'h12AB, 8'h00, 8'h00, 8'h00, 2'd2, 4'd2},  // R6 imm read
    '{4'd1,  2'd1, 16'h0000, 8'h00, 8'h00, 8'h77, 2'd1, 4'd2},  // R7 acc rmw
    '{4'd2,  2'd0, 16'h3344, 8'h00, 8'h00, 8'h00, 2'd2, 4'd3},  // R1 zp drops high byte
    '{4'd3,  2'd0, 16'h00F0, 8'h20, 8'h00, 8'h00, 2'd2, 4'd4},  // R1 zp,x wraps
    '{4'd4,  2'd2, 16'h0080, 8'h00, 8'h05, 8'h00, 2'd2, 4'd0},  // R8 unlisted store
    '{4'd5,  2'd1, 16'h1234, 8'h00, 8'h00, 8'h00, 2'd3, 4'd6},  // R7 abs rmw
    '{4'd6,  2'd0, 16'h12F0, 8'h20, 8'h00, 8'h00, 2'd3, 4'd5},  // R10 abs,x cross
    '{4'd6,  2'd0, 16'h1200, 8'h20, 8'h00, 8'h00, 2'd3, 4'd4},  // R10 abs,x no cross
    '{4'd7,  2'd2, 16'h12F0, 8'h00, 8'h20, 8'h00, 2'd3, 4'd5},  // R8 store cross no penalty
    '{4'd6,  2'd1, 16'h12F0, 8'h20, 8'h00, 8'h00, 2'd3, 4'd7},  // R7 rmw cross no penalty
    '{4'd7,  2'd0, 16'hFFF0, 8'h00, 8'h20, 8'h00, 2'd3, 4'd5},  // R1 abs,y wraps 64K
    '{4'd8,  2'd0, 16'h00FE, 8'h01, 8'h00, 8'h00, 2'd2, 4'd6},  // R2 pointer at 0xFF
    '{4'd9,  2'd0, 16'h0010, 8'h00, 8'hB0, 8'h00, 2'd2, 4'd6},  // R3 R10 ind,y cross
    '{4'd9,  2'd0, 16'h0010, 8'h00, 8'h10, 8'h00, 2'd2, 4'd5},  // R3 ind,y no cross
    '{4'd9,  2'd2, 16'h0010, 8'h00, 8'hB0, 8'h00, 2'd2, 4'd6},  // R8 ind,y store
    '{4'd10, 2'd3, 16'h0000, 8'h00, 8'h00, 8'h00, 2'd1, 4'd2},  // R9 implied
    '{4'd12, 2'd0, 16'h0005, 8'h00, 8'h00, 8'h00, 2'd2, 4'd0},  // R4 relative
    '{4'd11, 2'd3, 16'h4000, 8'h00, 8'h00, 8'h00, 2'd2, 4'd2},  // R4 indirect jump
    '{4'd3,  2'd1, 16'h0010, 8'h05, 8'h00, 8'h00, 2'd2, 4'd6},  // R7 zp,x rmw
    '{4'd2,  2'd2, 16'h0020, 8'h00, 8'h00, 8'h00, 2'd2, 4'd3},  // R8 zp store
    '{4'd0,  2'd2, 16'h0099, 8'h00, 8'h00, 8'h00, 2'd2, 4'd0},  // R8 imm store unlisted
    '{4'd7,  2'd1, 16'h2000, 8'h00, 8'h01, 8'h00, 2'd3, 4'd0},  // R7 abs,y rmw unlisted
    '{4'd13, 2'd0, 16'h1234, 8'h00, 8'h00, 8'h00, 2'd2, 4'd0},  // R4 reserved code
    '{4'd8,  2'd2, 16'h0030, 8'h02, 8'h00, 8'h00, 2'd2, 4'd6},  // R8 ind,x store
    '{4'd5,  2'd3, 16'h1234, 8'h00, 8'h00, 8'h00, 2'd3, 4'd2},  // R9 other with abs
    '{4'd5,  2'd0, 16'h0000, 8'h00, 8'h00, 8'h00, 2'd3, 4'd4}   // R6 abs read
  };

  // drives one operation and waits for done, sampling at negedges
  task automatic run_op(input logic [3:0] m, input logic [1:0] c, input logic [15:0] op,
                        input logic [7:0] x, input logic [7:0] y, input logic [7:0] a,
                        output bit got_done);
    @(negedge clk);
    mode = m; iclass = c; operand = op; idx_x = x; idx_y = y; acc = a;
    rd_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 1'b0;
    for (int i = 0; i < 40 && !got_done; i++) begin
      if (done) got_done = 1'b1;
      else @(negedge clk);
    end
  endtask

  initial begin
    bit ok;
    logic [15:0] e_ea;
    logic [7:0]  e_val;

    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!done && !busy && !mem_rd, "R12 idle flags", {done, busy, mem_rd}, 0);
    chk(eff_addr == 0 && value == 0 && length == 0 && cycles == 0, "R12 result outputs",
        {eff_addr, value, length, cycles}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      run_op(VT[k].m, VT[k].c, VT[k].op, VT[k].x, VT[k].y, VT[k].a, ok);
      chk(ok, "R11 done seen", ok, 1);
      e_ea  = ref_ea(VT[k].m, VT[k].op, VT[k].x, VT[k].y);
      e_val = ref_val(VT[k].m, VT[k].op, VT[k].x, VT[k].y, VT[k].a);
      chk(eff_addr == e_ea, "R1 R2 R3 effective address", eff_addr, e_ea);
      chk(value == e_val, "R4 value", value, e_val);
      chk(length == VT[k].len, "R5 length", length, VT[k].len);
      chk(cycles == VT[k].cyc, "R6 R7 R8 R9 R10 cycles", cycles, VT[k].cyc);
      chk(rd_cnt == ref_reads(VT[k].m), "R4 memory read count", rd_cnt, ref_reads(VT[k].m));
      @(negedge clk);
      chk(!done, "R11 done single clock", done, 0);
      chk(!busy, "R11 busy clears", busy, 0);
      // R11: results held while idle
      chk(eff_addr == e_ea && value == e_val, "R11 results held", eff_addr, e_ea);
    end

    // R11: start during busy is ignored
    @(negedge clk);
    mode = 4'd8; iclass = 2'd0; operand = 16'h0040; idx_x = 8'h03; idx_y = 8'h00;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mode = 4'd0; operand = 16'h5555; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int dcount = 0;
      for (int i = 0; i < 20; i++) begin
        if (done) dcount++;
        @(negedge clk);
      end
      chk(dcount == 1, "R11 one done for busy start", dcount, 1);
      e_ea = ref_ea(4'd8, 16'h0040, 8'h03, 8'h00);
      chk(eff_addr == e_ea, "R11 busy start ignored address", eff_addr, e_ea);
      chk(cycles == 4'd6, "R11 busy start ignored cycles", cycles, 6);
    end

    // R12: reset in the middle of an operation
    @(negedge clk);
    mode = 4'd9; iclass = 2'd0; operand = 16'h0010; idx_y = 8'hB0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_rd && !done, "R12 reset mid operation", {busy, mem_rd, done}, 0);
    chk(eff_addr == 0 && cycles == 0, "R12 reset clears results", {eff_addr, cycles}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy, "R12 idle after release", busy, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule